// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Compare Points

This block is one timer channel. It counts down from a programmable start value and advances by one on each cycle where the selected tick enable is high. That tick enable comes either from a per-cycle system tick or from a 1 MHz external enable pulse. When the count has stepped down to zero, the next tick loads the start value again, so the channel keeps running for as long as it is enabled.

Two compare values watch the count. A compare value only counts as such when it is strictly below the start value. A compare value at or above the start value behaves as if it were zero. The interrupt line is a level that flips on every interrupt event, so a consumer detects events by edges. An interrupt event happens when the count steps onto a nonzero qualified compare value, or when it reaches zero with the wrap-interrupt control set or with a qualified compare value of zero.

Software can write the count directly while the channel runs. When the start value moves from zero to nonzero, the channel restarts at once. The block has no data stream, so it has no valid/ready handshake. Every pin is plain control or status, and each write strobe takes effect on the clock edge where it is high.

Top module: `dmt_channel`

## Requirements
- R1: After reset, count_o reads 0, irq_o is low, and the channel is disabled. The start value and both compare values are 0.
- R2: While enabled and with no write strobe, the count falls by exactly one on each cycle where the selected tick is high, and holds on every other cycle.
- R3: With ctl_ext_sel = 1 the tick is ext_tick. With ctl_ext_sel = 0 the tick is bus_tick. The unselected tick has no effect on the count.
- R4: A tick that finds the count at 0 loads the start value into the count.
- R5: A compare value takes part only when it is strictly less than the start value. Otherwise it is treated as 0.
- R6: A tick that moves the count onto a nonzero qualified compare value is one interrupt event. Two equal compare values give a single event.
- R7: A tick that moves the count from 1 to 0 is an interrupt event exactly when ctl_wrap_irq = 1 or a qualified compare value is 0.
- R8: irq_o inverts once, on the clock edge that follows each interrupt event, and changes at no other time.
- R9: While disabled, count_o reads the start value, no interrupt event occurs, and irq_o holds its level.
- R10: A rising ctl_run loads the start value into the count. The first decrement happens on the next selected tick.
- R11: wr_count while the channel is enabled replaces the count with wr_data. It takes priority over a tick in the same cycle, and counting continues from the new value.
- R12: wr_reload always updates the start value. If the old start value was 0, the new one is nonzero and the channel is enabled, the count is loaded with the new value at once. Otherwise the running count is untouched and the new value first appears at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_run | input | 1 | Channel enable |
| ctl_ext_sel | input | 1 | Tick source: 1 = ext_tick, 0 = bus_tick |
| ctl_wrap_irq | input | 1 | Request an event when the count reaches zero |
| bus_tick | input | 1 | System-rate tick enable |
| ext_tick | input | 1 | 1 MHz external tick enable, single-cycle pulse |
| wr_count | input | 1 | Write strobe for the count |
| wr_reload | input | 1 | Write strobe for the start value |
| wr_cmp_a | input | 1 | Write strobe for compare value A |
| wr_cmp_b | input | 1 | Write strobe for compare value B |
| wr_data | input | W | Data for any write strobe |
| count_o | output | W | Live count when enabled, start value when disabled |
| irq_o | output | 1 | Interrupt level, inverted per event |

## Verification
The properties assume that the tick pins and write strobes are synchronous and settle before each rising edge. The step and wrap properties exclude cycles that carry a count or start-value write, because those writes take priority over a tick. The stimulus changes every input on the falling edge. It raises at most one write strobe per cycle and programs the compare values and start value only while the channel is disabled, except in the scenarios that exercise R11 and R12. The main sweep covers start values 1 to 5, every compare pair from 0 to 6 and both wrap settings. For each case it counts the edges of irq_o over one full period and compares that count with a figure worked out from R5 to R7.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic {
    TICK_BUS = 1'b0,
    TICK_EXT = 1'b1
  } tick_src_e;

  localparam int DMT_N_CMP = 2;
endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel
  import dmt_pkg::*;
(
  input  tick_src_e src_i,
  input  logic      bus_tick_i,
  input  logic      ext_tick_i,
  output logic      tick_o
);
  always_comb begin
    unique case (src_i)
      TICK_EXT: tick_o = ext_tick_i;
      default:  tick_o = bus_tick_i;
    endcase
  end
endmodule

// File: rtl/dmt_qualify.sv
module dmt_qualify #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic [N-1:0][W-1:0] cmp_i,
  input  logic [W-1:0]        reload_i,
  output logic [N-1:0][W-1:0] qual_o,
  output logic                any_zero_o
);
  logic [N-1:0] is_zero;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    // a compare value at or above the start value collapses to zero
    assign qual_o[i]  = (cmp_i[i] < reload_i) ? cmp_i[i] : '0;
    assign is_zero[i] = (qual_o[i] == '0);
  end

  assign any_zero_o = |is_zero;
endmodule

// File: rtl/dmt_core.sv
module dmt_core #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic                wrap_irq_i,
  input  logic                wr_count_i,
  input  logic                wr_reload_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic [W-1:0]        reload_i,
  input  logic [N-1:0][W-1:0] qual_i,
  input  logic                any_zero_i,
  output logic [W-1:0]        cnt_o,
  output logic                run_q_o,
  output logic                event_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d, dec;
  logic         run_q;
  logic         rise, live, kick, step;
  logic [N-1:0] hit;

  assign dec  = cnt_q - ONE;
  assign rise = run_i & ~run_q;
  assign live = run_i & run_q;
  assign kick = live & wr_reload_i & (reload_i == '0) & (wr_data_i != '0);
  assign step = live & tick_i & ~wr_count_i & ~kick;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (qual_i[i] == dec);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (rise)                  cnt_d = reload_i;
    else if (live & wr_count_i) cnt_d = wr_data_i;
    else if (kick)             cnt_d = wr_data_i;
    else if (step)             cnt_d = (cnt_q == '0) ? reload_i : dec;
  end

  always_comb begin
    event_o = 1'b0;
    if (step && cnt_q != '0) begin
      if (dec == '0) event_o = wrap_irq_i | any_zero_i;
      else           event_o = |hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign run_q_o = run_q;
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_run,
  input  logic         ctl_ext_sel,
  input  logic         ctl_wrap_irq,
  input  logic         bus_tick,
  input  logic         ext_tick,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic         wr_cmp_a,
  input  logic         wr_cmp_b,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic         irq_o
);
  localparam int N = DMT_N_CMP;

  logic [W-1:0]        reload_q;
  logic [N-1:0][W-1:0] cmp_q;
  logic [N-1:0][W-1:0] qual;
  logic [N-1:0]        wr_cmp;
  logic                any_zero, tick, evt, run_q, irq_q;
  logic [W-1:0]        cnt;

  assign wr_cmp = {wr_cmp_b, wr_cmp_a};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wr_data;
      if (evt)       irq_q    <= ~irq_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cmp_reg
    always_ff @(posedge clk) begin
      if (!rst_n)         cmp_q[i] <= '0;
      else if (wr_cmp[i]) cmp_q[i] <= wr_data;
    end
  end

  dmt_tick_sel u_tick (
    .src_i      (tick_src_e'(ctl_ext_sel)),
    .bus_tick_i (bus_tick),
    .ext_tick_i (ext_tick),
    .tick_o     (tick)
  );

  dmt_qualify #(.W(W), .N(N)) u_qual (
    .cmp_i      (cmp_q),
    .reload_i   (reload_q),
    .qual_o     (qual),
    .any_zero_o (any_zero)
  );

  dmt_core #(.W(W), .N(N)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctl_run),
    .tick_i      (tick),
    .wrap_irq_i  (ctl_wrap_irq),
    .wr_count_i  (wr_count),
    .wr_reload_i (wr_reload),
    .wr_data_i   (wr_data),
    .reload_i    (reload_q),
    .qual_i      (qual),
    .any_zero_i  (any_zero),
    .cnt_o       (cnt),
    .run_q_o     (run_q),
    .event_o     (evt)
  );

  assign count_o = run_q ? cnt : reload_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dmt_channel_chk.sv
module dmt_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_run,
  input logic         ctl_ext_sel,
  input logic         bus_tick,
  input logic         ext_tick,
  input logic         wr_count,
  input logic         wr_reload,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] reload_q,
  input logic [W-1:0] count_o,
  input logic         irq_o
);
  logic sel_tick;
  logic quiet_wr;
  assign sel_tick = ctl_ext_sel ? ext_tick : bus_tick;
  assign quiet_wr = !wr_count && !wr_reload;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && sel_tick && quiet_wr && count_o != '0)
    |=> count_o == $past(count_o) - 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && !sel_tick && quiet_wr)
    |=> $stable(count_o));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && sel_tick && quiet_wr && count_o == '0)
    |=> count_o == $past(reload_q));

  p_irq_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_o) |-> $past(sel_tick));

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> $stable(irq_o));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && !$past(ctl_run)) |=> count_o == $past(reload_q));

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && $past(ctl_run) && wr_count) |=> count_o == $past(wr_data));
endmodule

bind dmt_channel dmt_channel_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_run     (ctl_run),
  .ctl_ext_sel (ctl_ext_sel),
  .bus_tick    (bus_tick),
  .ext_tick    (ext_tick),
  .wr_count    (wr_count),
  .wr_reload   (wr_reload),
  .wr_data     (wr_data),
  .reload_q    (reload_q),
  .count_o     (count_o),
  .irq_o       (irq_o)
);

// File: tb/test_dmt_channel.sv
module test_dmt_channel;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_run = 0, ctl_ext_sel = 0, ctl_wrap_irq = 0;
  logic bus_tick = 0, ext_tick = 0;
  logic wr_count = 0, wr_reload = 0, wr_cmp_a = 0, wr_cmp_b = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o;
  logic         irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dmt_channel #(.W(W)) i_dmt_channel (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_ext_sel(ctl_ext_sel),
    .ctl_wrap_irq(ctl_wrap_irq), .bus_tick(bus_tick), .ext_tick(ext_tick),
    .wr_count(wr_count), .wr_reload(wr_reload), .wr_cmp_a(wr_cmp_a),
    .wr_cmp_b(wr_cmp_b), .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // which: 0 count, 1 start value, 2 compare A, 3 compare B
  task automatic wreg(input int which, input logic [W-1:0] v);
    wr_data   = v;
    wr_count  = (which == 0);
    wr_reload = (which == 1);
    wr_cmp_a  = (which == 2);
    wr_cmp_b  = (which == 3);
    cyc();
    wr_count = 0; wr_reload = 0; wr_cmp_a = 0; wr_cmp_b = 0;
  endtask

  function automatic int expect_events(int r, int a, int b, int wrap);
    int qa = (a < r) ? a : 0;
    int qb = (b < r) ? b : 0;
    int e = 0;
    if (qa != 0) e++;
    if (qb != 0 && qb != qa) e++;
    if (wrap != 0 || qa == 0 || qb == 0) e++;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic prev_irq;
    int   tog;
    int   cnt_exp;

    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(count_o == 0, "R1 count after reset", count_o, 0);
    chk(irq_o == 0, "R1 irq after reset", irq_o, 0);

    // R9: disabled readback shows start value
    wreg(1, 50);
    chk(count_o == 50, "R9 disabled readback", count_o, 50);

    // R3 / R2: external tick source
    wreg(1, 100);
    ctl_ext_sel = 1; bus_tick = 1; ctl_run = 1;
    cyc();
    chk(count_o == 100, "R10 start on enable", count_o, 100);
    cnt_exp = 100;
    for (int i = 0; i < 12; i++) begin
      ext_tick = (i % 3 == 0);
      cyc();
      if (ext_tick) cnt_exp--;
    end
    ext_tick = 0;
    chk(count_o == cnt_exp, "R3 ext tick counted", count_o, cnt_exp);
    ctl_ext_sel = 0; bus_tick = 0; ext_tick = 1;
    repeat (5) cyc();
    chk(count_o == cnt_exp, "R2 no tick no change", count_o, cnt_exp);
    ext_tick = 0; bus_tick = 1;
    repeat (3) cyc();
    chk(count_o == cnt_exp - 3, "R3 bus tick counted", count_o, cnt_exp - 3);

    // R11: count write while running
    wreg(0, 3);
    chk(count_o == 3, "R11 count write", count_o, 3);
    cyc();
    chk(count_o == 2, "R11 continue after write", count_o, 2);
    repeat (2) cyc();
    chk(count_o == 0, "R2 reach zero", count_o, 0);
    cyc();
    chk(count_o == 100, "R4 wrap to start value", count_o, 100);

    // R9: freeze while disabled, R10 restart
    ctl_run = 0;
    wreg(1, 10); wreg(2, 9); wreg(3, 8);
    ctl_wrap_irq = 1;
    ctl_run = 1; cyc();
    repeat (4) cyc();
    ctl_run = 0; cyc();
    prev_irq = irq_o;
    repeat (20) cyc();
    chk(irq_o == prev_irq, "R9 irq held while disabled", irq_o, prev_irq);
    chk(count_o == 10, "R9 frozen readback", count_o, 10);
    ctl_run = 1; cyc();
    chk(count_o == 10, "R10 restart from start value", count_o, 10);
    cyc();
    chk(count_o == 9, "R2 first step", count_o, 9);
    chk(irq_o != prev_irq, "R8 irq toggles on match", irq_o, !prev_irq);

    // R12: start value zero -> nonzero while running
    ctl_run = 0; ctl_wrap_irq = 0;
    wreg(1, 0); wreg(2, 0); wreg(3, 0);
    ctl_run = 1; cyc();
    repeat (3) cyc();
    chk(count_o == 0, "R12 zero start value idles", count_o, 0);
    wreg(1, 9);
    chk(count_o == 9, "R12 immediate load", count_o, 9);
    cyc();
    chk(count_o == 8, "R12 counting after load", count_o, 8);
    wreg(1, 20);
    chk(count_o == 7, "R12 later write leaves count", count_o, 7);
    repeat (7) cyc();
    chk(count_o == 0, "R12 reach zero", count_o, 0);
    cyc();
    chk(count_o == 20, "R12 new start value at wrap", count_o, 20);

    // Sweep: R5 R6 R7 R8 over start values, compare pairs, wrap setting
    for (int r = 1; r <= 5; r++) begin
      for (int a = 0; a <= 6; a++) begin
        for (int b = 0; b <= 6; b++) begin
          for (int wrap = 0; wrap <= 1; wrap++) begin
            ctl_run = 0; bus_tick = 1;
            cyc();
            wreg(1, r); wreg(2, a); wreg(3, b);
            ctl_wrap_irq = wrap[0];
            ctl_run = 1; cyc();
            chk(count_o == r, "R10 sweep start", count_o, r);
            prev_irq = irq_o; tog = 0;
            for (int k = 0; k <= r; k++) begin
              cyc();
              if (irq_o != prev_irq) tog++;
              prev_irq = irq_o;
            end
            chk(tog == expect_events(r, a, b, wrap),
                "R5 R6 R7 R8 events per period", tog, expect_events(r, a, b, wrap));
            chk(count_o == r, "R4 sweep wrap", count_o, r);
          end
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule